// File: doc/BRIEF.md
# Level-Banked General Register File

This block holds the general-purpose registers of a processor that runs code at several program priority levels. There are forty 24-bit registers in five banks of eight. Each bank belongs to one priority level. The processor addresses a register with a 3-bit number, and a level input picks the bank that number refers to. Registers in the other banks cannot be reached, so each level keeps its own private working set. The logic that switches levels sits outside the block and only drives the level input.

Each 24-bit word is split into three byte lanes. Counting from the most significant end, they are byte X (bits 23:16), byte 0 (bits 15:8) and byte 1 (bits 7:0). One write port takes a per-lane byte enable, so a single byte can be updated without a read-modify-write. Two read ports return whole words one clock after they are addressed, from registers. A level value that names no bank is refused: writes are dropped, both reads return zero, and an error flag is raised.

Top module: `lvl_rf_top`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared. After reset, every register in every bank reads as zero, and `level_err` is 0.
- R2: A write with `we`=1 at a rising edge stores `wdata` in register `waddr` of bank `level`. A read issued at any later edge returns that value.
- R3: Register number n in bank L and register number n in bank M (L≠M) are independent. A write to one never changes the other.
- R4: `wbe` bit 2 enables byte X (`wdata[23:16]`), bit 1 enables byte 0 (`wdata[15:8]`) and bit 0 enables byte 1 (`wdata[7:0]`). Lanes whose enable is 0 keep their old contents.
- R5: When the write port and a read port address the same register at the same edge, the read returns the value from before the write.
- R6: The two read ports are independent. Each returns the register named by its own address, in the same cycle, including when both name the same register.
- R7: A `level` above 4 is rejected. No register in any bank changes. At the following edge `level_err` becomes 1 and both read outputs become zero. A valid level clears `level_err` at the next edge.
- R8: Read data is registered. `rdata_a`/`rdata_b` change only at a rising edge, and they reflect the address and level presented at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| level | input | 3 | Active program level; selects bank 0..4 |
| we | input | 1 | Write enable |
| wbe | input | 3 | Byte-lane enables: [2]=byte X, [1]=byte 0, [0]=byte 1 |
| waddr | input | 3 | Register number for the write |
| wdata | input | 24 | Write data, byte X in the top lane |
| raddr_a | input | 3 | Register number for read port A |
| raddr_b | input | 3 | Register number for read port B |
| rdata_a | output | 24 | Registered read data, port A |
| rdata_b | output | 24 | Registered read data, port B |
| level_err | output | 1 | Registered flag: the previous level was out of range |

## Verification
The case that is hardest to reach from the ports is a rejected level. It must leave all forty registers untouched, yet the only evidence is that every bank still reads back exactly as before. The bench first fills every bank with distinct, arithmetically derived words. It then attempts full-lane writes at levels 5, 6 and 7, and afterwards sweeps all forty registers through both read ports against its own model. Read-during-write is driven by presenting the same register on the write port and on read port A in one cycle, and checking the old word there before re-reading the new one.

// File: rtl/lvl_rf_pkg.sv
package lvl_rf_pkg;
  parameter int LANE_W  = 8;
  parameter int N_LANES = 3;
  parameter int WORD_W  = LANE_W * N_LANES;

  // lane index inside a word; byte X is the most significant lane
  typedef enum logic [1:0] {
    LANE_B1 = 2'd0,
    LANE_B0 = 2'd1,
    LANE_BX = 2'd2
  } lane_e;
endpackage

// File: rtl/lvl_rf_bank_sel.sv
module lvl_rf_bank_sel #(
  parameter int N_LEVELS = 5,
  parameter int REGS     = 8,
  parameter int LEVEL_W  = 3,
  parameter int REG_W    = $clog2(REGS),
  parameter int IDX_W    = $clog2(N_LEVELS * REGS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LEVEL_W-1:0] level,
  input  logic               we,
  input  logic [REG_W-1:0]   waddr,
  input  logic [REG_W-1:0]   raddr_a,
  input  logic [REG_W-1:0]   raddr_b,
  output logic [IDX_W-1:0]   widx,
  output logic [IDX_W-1:0]   ridx_a,
  output logic [IDX_W-1:0]   ridx_b,
  output logic               wr_ok,
  output logic               lvl_ok_q,
  output logic               err_q
);
  logic lvl_ok;

  function automatic logic [IDX_W-1:0] flat(input logic [LEVEL_W-1:0] l,
                                            input logic [REG_W-1:0] r);
    int v;
    v = int'(l) * REGS + int'(r);
    return IDX_W'(v);
  endfunction

  assign lvl_ok = (int'(level) < N_LEVELS);
  assign wr_ok  = we && lvl_ok;
  assign widx   = lvl_ok ? flat(level, waddr)   : '0;
  assign ridx_a = lvl_ok ? flat(level, raddr_a) : '0;
  assign ridx_b = lvl_ok ? flat(level, raddr_b) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_ok_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      lvl_ok_q <= lvl_ok;
      err_q    <= !lvl_ok;
    end
  end

  // R7: a write strobe never leaves this block with a level outside the banks
  p_no_bad_write_r7: assert property (@(posedge clk) disable iff (rst)
    (int'(level) >= N_LEVELS) |-> !wr_ok);
endmodule

// File: rtl/lvl_rf_lane_mem.sv
module lvl_rf_lane_mem #(
  parameter int DEPTH = 40,
  parameter int W     = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [W-1:0]     wdata,
  input  logic [IDX_W-1:0] ridx_a,
  input  logic [IDX_W-1:0] ridx_b,
  output logic [W-1:0]     q_a,
  output logic [W-1:0]     q_b
);
  logic [W-1:0] mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [W-1:0] raw_a, raw_b;
  logic vld_a, vld_b;

  // data array without reset so it can map onto RAM; reads see the old word
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    raw_a <= mem[ridx_a];
    raw_b <= mem[ridx_b];
  end

  // per-entry written flags give the cleared-by-reset view
  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= '0;
      vld_a <= 1'b0;
      vld_b <= 1'b0;
    end else begin
      if (we) vld[widx] <= 1'b1;
      vld_a <= vld[ridx_a];
      vld_b <= vld[ridx_b];
    end
  end

  assign q_a = vld_a ? raw_a : '0;
  assign q_b = vld_b ? raw_b : '0;

  // R1: reset leaves no entry marked as written
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (vld == '0));
  // R4: a lane without its enable keeps its written-state untouched
  p_lane_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(vld));
  // R7: writes only land inside the populated depth
  p_idx_range_r7: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(widx) < DEPTH));
endmodule

// File: rtl/lvl_rf_top.sv
module lvl_rf_top
  import lvl_rf_pkg::*;
#(
  parameter int N_LEVELS = 5,
  parameter int REGS     = 8,
  parameter int LEVEL_W  = 3,
  parameter int REG_W    = $clog2(REGS),
  parameter int DW       = WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LEVEL_W-1:0] level,
  input  logic               we,
  input  logic [N_LANES-1:0] wbe,
  input  logic [REG_W-1:0]   waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [REG_W-1:0]   raddr_a,
  input  logic [REG_W-1:0]   raddr_b,
  output logic [DW-1:0]      rdata_a,
  output logic [DW-1:0]      rdata_b,
  output logic               level_err
);
  localparam int DEPTH = N_LEVELS * REGS;
  localparam int IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] widx, ridx_a, ridx_b;
  logic wr_ok, lvl_ok_q;
  logic [DW-1:0] word_a, word_b;

  lvl_rf_bank_sel #(
    .N_LEVELS(N_LEVELS), .REGS(REGS), .LEVEL_W(LEVEL_W),
    .REG_W(REG_W), .IDX_W(IDX_W)
  ) i_sel (
    .clk(clk), .rst(rst), .level(level), .we(we),
    .waddr(waddr), .raddr_a(raddr_a), .raddr_b(raddr_b),
    .widx(widx), .ridx_a(ridx_a), .ridx_b(ridx_b),
    .wr_ok(wr_ok), .lvl_ok_q(lvl_ok_q), .err_q(level_err)
  );

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    lvl_rf_lane_mem #(.DEPTH(DEPTH), .W(LANE_W), .IDX_W(IDX_W)) i_lane (
      .clk(clk), .rst(rst),
      .we(wr_ok && wbe[g]),
      .widx(widx),
      .wdata(wdata[g*LANE_W +: LANE_W]),
      .ridx_a(ridx_a), .ridx_b(ridx_b),
      .q_a(word_a[g*LANE_W +: LANE_W]),
      .q_b(word_b[g*LANE_W +: LANE_W])
    );
  end

  assign rdata_a = lvl_ok_q ? word_a : '0;
  assign rdata_b = lvl_ok_q ? word_b : '0;

  // R7: the error flag tracks the level seen one edge earlier
  p_err_follows_level_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (level_err == $past(int'(level) >= N_LEVELS)));
  // R7: reads after a rejected level are zero
  p_bad_read_zero_r7: assert property (@(posedge clk) disable iff (rst)
    level_err |-> (rdata_a == '0 && rdata_b == '0));
  // R6: both ports agree when they name the same register
  p_same_port_match_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(raddr_a == raddr_b)) |-> (rdata_a == rdata_b));
endmodule

// File: tb/test_lvl_rf_top.sv
module test_lvl_rf_top;
  logic clk = 1'b0;
  logic rst;
  logic [2:0] level;
  logic we;
  logic [2:0] wbe;
  logic [2:0] waddr, raddr_a, raddr_b;
  logic [23:0] wdata;
  logic [23:0] rdata_a, rdata_b;
  logic level_err;

  int n_chk = 0;
  int n_fail = 0;
  logic [23:0] model [40];

  lvl_rf_top i_lvl_rf_top (
    .clk(clk), .rst(rst), .level(level), .we(we), .wbe(wbe),
    .waddr(waddr), .wdata(wdata), .raddr_a(raddr_a), .raddr_b(raddr_b),
    .rdata_a(rdata_a), .rdata_b(rdata_b), .level_err(level_err)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [23:0] pat(input int l, input int r, input int salt);
    return 24'((l * 8 + r + 1) * 24'h0A1B3 + salt * 24'h351);
  endfunction

  task automatic wr(input int l, input int a, input logic [2:0] be, input logic [23:0] d);
    level = 3'(l); we = 1'b1; wbe = be; waddr = 3'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (l < 5)
      for (int k = 0; k < 3; k++)
        if (be[k]) model[l*8+a][k*8 +: 8] = d[k*8 +: 8];
  endtask

  task automatic rd(input string req, input int l, input int a, input int b);
    level = 3'(l); raddr_a = 3'(a); raddr_b = 3'(b);
    @(negedge clk);
    chk(req, rdata_a, (l < 5) ? model[l*8+a] : 24'h0);
    chk(req, rdata_b, (l < 5) ? model[l*8+b] : 24'h0);
  endtask

  task automatic sweep(input string req);
    for (int l = 0; l < 5; l++)
      for (int r = 0; r < 8; r++) rd(req, l, r, 7 - r);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 40; i++) model[i] = 24'h0;
    rst = 1'b1; level = 3'd0; we = 1'b0; wbe = 3'b000;
    waddr = 3'd0; wdata = 24'h0; raddr_a = 3'd0; raddr_b = 3'd0;
    repeat (3) @(negedge clk);
    // R1: outputs after reset, then every register reads zero
    chk("R1", rdata_a, 24'h0);
    chk("R1", {23'h0, level_err}, 24'h0);
    rst = 1'b0;
    sweep("R1");
    // R2/R3: distinct full words in every bank
    for (int l = 0; l < 5; l++)
      for (int r = 0; r < 8; r++) wr(l, r, 3'b111, pat(l, r, 0));
    sweep("R2_R3_R6");
    // R6: both ports on the same register
    for (int r = 0; r < 8; r++) rd("R6", 3, r, r);
    // R4: every partial lane-enable pattern (2=byte X,1=byte 0,0=byte 1)
    for (int l = 0; l < 5; l++)
      for (int be = 1; be < 7; be++) wr(l, be, 3'(be), pat(l, be, 7) ^ 24'hFFFFFF);
    sweep("R4");
    // R5: read the register being written in the same cycle
    level = 3'd2; we = 1'b1; wbe = 3'b111; waddr = 3'd3; wdata = 24'hC0FFEE;
    raddr_a = 3'd3; raddr_b = 3'd4;
    @(negedge clk);
    we = 1'b0;
    chk("R5", rdata_a, model[2*8+3]);
    model[2*8+3] = 24'hC0FFEE;
    rd("R5", 2, 3, 3);
    // R8: output holds until the next rising edge
    rd("R8", 1, 0, 1);
    raddr_a = 3'd5;
    #1;
    chk("R8", rdata_a, model[1*8+0]);
    @(negedge clk);
    chk("R8", rdata_a, model[1*8+5]);
    // R7: out-of-range levels reject writes and flag an error
    for (int l = 5; l < 8; l++) begin
      for (int r = 0; r < 8; r++) begin
        wr(l, r, 3'b111, 24'hBAD000 + 24'(r));
        chk("R7", {23'h0, level_err}, 24'h1);
      end
      rd("R7", l, 0, 7);
      chk("R7", {23'h0, level_err}, 24'h1);
    end
    rd("R7", 0, 0, 1);
    chk("R7", {23'h0, level_err}, 24'h0);
    sweep("R7_R3");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule